// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Sequencer

This block produces the serial clock and the chip-select window of an SPI master from the system clock. A single start pulse launches one frame. The frame asserts chip-select and waits a programmed lead interval. It then runs a programmed number of SCK cycles, waits a programmed trail interval and releases chip-select. Each of the three timings is set by a 2-bit prescaler code and a 4-bit scaler code. The baud timing uses one pair of tables and the two delays share a second pair, so very different rates are reachable with only six bits per timing. Converting a wanted frequency or delay into codes is the job of software or of a neighbouring block.

The controller is a six-state machine. IDLE waits for start (transition IDLE→LEAD). LEAD counts the lead delay and goes to HALF_A, or straight to TRAIL when the bit count is zero. HALF_A holds SCK at its active level for half a period and then goes to HALF_B. HALF_B holds SCK at its idle level for the other half. From HALF_B the machine returns to HALF_A while bits remain and goes to TRAIL after the last bit. TRAIL counts the trail delay and goes to FINISH. FINISH lasts one cycle, pulses done and returns to IDLE. One shared down-counter times every state. All codes, the bit count and CPOL are captured at start.

Top module: `sck_cs_timer`

## Requirements
- R1: While reset is held and in the first cycle after reset, cs_act, done, edge_lead and edge_trail are low.
- R2: The SCK period P is the baud prescaler factor times the baud scaler value. Prescaler codes 0,1,2,3 give 2,3,5,7. Scaler codes 0..3 give 2,4,6,8, and scaler code k≥4 gives 2^k. Within each bit SCK first sits at the inverse of CPOL for P/2 clocks, then at CPOL for P/2 clocks. Outside a frame SCK equals the live cpol input.
- R3: A delay D is the delay prescaler factor times the delay scaler value. Prescaler codes 0,1,2,3 give 1,3,5,7, and scaler code j gives 2^(j+1). chip-select is high for exactly D_lead clocks before the first cycle flagged by edge_lead.
- R4: After the idle half of the last bit ends, chip-select stays high for exactly D_trail clocks.
- R5: A frame with nbits>0 shows exactly nbits edge_lead pulses and nbits edge_trail pulses, one at the first cycle of each SCK half. chip-select is high for D_lead + nbits·P + D_trail clocks in total.
- R6: A frame with nbits=0 produces no SCK activity and no edge strobes. chip-select is high for D_lead + D_trail clocks.
- R7: done is a one-cycle pulse, once per frame, in the first cycle with chip-select low after the frame.
- R8: Changes to the codes or to nbits after the start cycle do not affect the running frame.
- R9: start is ignored while a frame runs and in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame launch, sampled in IDLE |
| nbits | input | NBITS_W | Number of SCK cycles in the frame |
| cpol | input | 1 | SCK idle level |
| baud_pre | input | 2 | Baud prescaler code |
| baud_scl | input | 4 | Baud scaler code |
| lead_pre | input | 2 | Lead-delay prescaler code |
| lead_scl | input | 4 | Lead-delay scaler code |
| trail_pre | input | 2 | Trail-delay prescaler code |
| trail_scl | input | 4 | Trail-delay scaler code |
| sck | output | 1 | Serial clock |
| cs_act | output | 1 | Chip-select enable, active high |
| edge_lead | output | 1 | First cycle of each active SCK half |
| edge_trail | output | 1 | First cycle of each idle SCK half |
| done | output | 1 | End-of-frame pulse |

## Verification
The assertions check several local rules on every cycle. done never coincides with chip-select and never lasts two cycles. chip-select never rises together with a clock edge. The shift states never run with a zero bit count. Captured codes never change mid-frame. FINISH always returns to IDLE, and the interval counter never wraps. The exact lengths of the lead, half-period and trail intervals, the edge counts and the total window depend on the table decoding. Only the bench's frames over varied code pairs can show these, along with immunity to code changes and to repeated starts.

// File: rtl/sck_timer_pkg.sv
package sck_timer_pkg;

    // Longest interval: delay prescaler 7 times scaler 2^16
    localparam int MAX_INTERVAL = 7 * 65536;
    localparam int CNT_W        = $clog2(MAX_INTERVAL + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HALF_A,
        ST_HALF_B,
        ST_TRAIL,
        ST_FINISH
    } tstate_t;

    typedef struct packed {
        logic [1:0] baud_pre;
        logic [3:0] baud_scl;
        logic [1:0] lead_pre;
        logic [3:0] lead_scl;
        logic [1:0] trail_pre;
        logic [3:0] trail_scl;
    } timing_codes_t;

endpackage

// File: rtl/tick_len_decode.sv
module tick_len_decode
    import sck_timer_pkg::*;
#(
    parameter bit DELAY_TABLE = 1'b0
) (
    input  logic [1:0]       pre,
    input  logic [3:0]       scl,
    output logic [CNT_W-1:0] len
);
    logic [CNT_W-1:0] pre_f;
    logic [CNT_W-1:0] scl_v;

    generate
        if (DELAY_TABLE) begin : g_delay
            // odd prescaler 1,3,5,7 ; scaler 2^(j+1)
            always_comb begin
                pre_f = CNT_W'({pre, 1'b1});
                scl_v = CNT_W'(2) << scl;
            end
        end else begin : g_baud
            // prescaler 2,3,5,7 ; scaler 2,4,6,8 then 2^k
            always_comb begin
                unique case (pre)
                    2'd0: pre_f = CNT_W'(2);
                    2'd1: pre_f = CNT_W'(3);
                    2'd2: pre_f = CNT_W'(5);
                    default: pre_f = CNT_W'(7);
                endcase
                if (scl < 4'd4)
                    scl_v = CNT_W'({scl, 1'b0}) + CNT_W'(2);
                else
                    scl_v = CNT_W'(1) << scl;
            end
        end
    endgenerate

    assign len = pre_f * scl_v;

endmodule

// File: rtl/interval_counter.sv
module interval_counter #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);

    // R4: an expired interval stays expired until reloaded (no wrap)
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/sck_cs_timer.sv
module sck_cs_timer
    import sck_timer_pkg::*;
#(
    parameter int NBITS_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NBITS_W-1:0] nbits,
    input  logic               cpol,
    input  logic [1:0]         baud_pre,
    input  logic [3:0]         baud_scl,
    input  logic [1:0]         lead_pre,
    input  logic [3:0]         lead_scl,
    input  logic [1:0]         trail_pre,
    input  logic [3:0]         trail_scl,
    output logic               sck,
    output logic               cs_act,
    output logic               edge_lead,
    output logic               edge_trail,
    output logic               done
);
    tstate_t          state_q, nxt;
    timing_codes_t    codes_in, codes_q, codes_sel;
    logic             cpol_q, cpol_sel;
    logic [NBITS_W-1:0] bits_left;
    logic [CNT_W-1:0] baud_len, lead_len, trail_len, half_len, ld_val;
    logic             ld, cnt_zero;
    logic             cs_q, edge_lead_q, edge_trail_q, done_q, sck_act_q;

    always_comb begin
        codes_in.baud_pre  = baud_pre;
        codes_in.baud_scl  = baud_scl;
        codes_in.lead_pre  = lead_pre;
        codes_in.lead_scl  = lead_scl;
        codes_in.trail_pre = trail_pre;
        codes_in.trail_scl = trail_scl;
    end

    // live codes in IDLE so the lead interval loads on the start edge
    assign codes_sel = (state_q == ST_IDLE) ? codes_in : codes_q;
    assign cpol_sel  = (state_q == ST_IDLE) ? cpol : cpol_q;

    tick_len_decode #(.DELAY_TABLE(1'b0)) u_baud (
        .pre(codes_sel.baud_pre), .scl(codes_sel.baud_scl), .len(baud_len));
    tick_len_decode #(.DELAY_TABLE(1'b1)) u_lead (
        .pre(codes_sel.lead_pre), .scl(codes_sel.lead_scl), .len(lead_len));
    tick_len_decode #(.DELAY_TABLE(1'b1)) u_trail (
        .pre(codes_sel.trail_pre), .scl(codes_sel.trail_scl), .len(trail_len));

    assign half_len = baud_len >> 1;

    interval_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .zero(cnt_zero));

    // next state and counter reload
    always_comb begin
        nxt    = state_q;
        ld     = 1'b0;
        ld_val = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    nxt    = ST_LEAD;
                    ld     = 1'b1;
                    ld_val = lead_len - CNT_W'(1);
                end
            end
            ST_LEAD: begin
                if (cnt_zero) begin
                    ld = 1'b1;
                    if (bits_left == '0) begin
                        nxt    = ST_TRAIL;
                        ld_val = trail_len - CNT_W'(1);
                    end else begin
                        nxt    = ST_HALF_A;
                        ld_val = half_len - CNT_W'(1);
                    end
                end
            end
            ST_HALF_A: begin
                if (cnt_zero) begin
                    nxt    = ST_HALF_B;
                    ld     = 1'b1;
                    ld_val = half_len - CNT_W'(1);
                end
            end
            ST_HALF_B: begin
                if (cnt_zero) begin
                    ld = 1'b1;
                    if (bits_left == NBITS_W'(1)) begin
                        nxt    = ST_TRAIL;
                        ld_val = trail_len - CNT_W'(1);
                    end else begin
                        nxt    = ST_HALF_A;
                        ld_val = half_len - CNT_W'(1);
                    end
                end
            end
            ST_TRAIL: begin
                if (cnt_zero)
                    nxt = ST_FINISH;
            end
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register and frame capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            codes_q   <= '0;
            cpol_q    <= 1'b0;
            bits_left <= '0;
        end else begin
            state_q <= nxt;
            if (state_q == ST_IDLE && start) begin
                codes_q   <= codes_in;
                cpol_q    <= cpol;
                bits_left <= nbits;
            end else if (state_q == ST_HALF_B && cnt_zero) begin
                bits_left <= bits_left - NBITS_W'(1);
            end
        end
    end

    // registered outputs, aligned with the state they describe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q         <= 1'b0;
            edge_lead_q  <= 1'b0;
            edge_trail_q <= 1'b0;
            done_q       <= 1'b0;
            sck_act_q    <= 1'b0;
        end else begin
            cs_q         <= (nxt == ST_LEAD) || (nxt == ST_HALF_A) ||
                            (nxt == ST_HALF_B) || (nxt == ST_TRAIL);
            edge_lead_q  <= (nxt == ST_HALF_A) && (state_q != ST_HALF_A);
            edge_trail_q <= (nxt == ST_HALF_B) && (state_q != ST_HALF_B);
            done_q       <= (nxt == ST_FINISH);
            sck_act_q    <= (nxt == ST_HALF_A);
        end
    end

    assign sck        = sck_act_q ? ~cpol_sel : cpol_sel;
    assign cs_act     = cs_q;
    assign edge_lead  = edge_lead_q;
    assign edge_trail = edge_trail_q;
    assign done       = done_q;

    // R7: done only with chip-select released, and only for one cycle
    a_r7_done_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cs_act);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3: the lead interval separates chip-select from the first edge
    a_r3_no_edge_at_assert: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_act) |-> !edge_lead);
    // R5: shifting never runs with an exhausted bit count
    a_r5_bits_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALF_A || state_q == ST_HALF_B) |-> (bits_left != '0));
    // R2: a leading edge leaves SCK at the active level
    a_r2_edge_level: assert property (@(posedge clk) disable iff (!rst_n)
        edge_lead |-> (sck != cpol_q));
    // R8: captured codes hold outside IDLE
    a_r8_codes_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(codes_q));
    // R9: the done cycle always returns to IDLE, start or not
    a_r9_finish_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |=> (state_q == ST_IDLE));

endmodule

// File: tb/sim_sck_cs_timer.sv
module sim_sck_cs_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;

    typedef struct packed {
        logic [1:0] bp; logic [3:0] bs;
        logic [1:0] lp; logic [3:0] ls;
        logic [1:0] tp; logic [3:0] ts;
        logic       cp; logic [5:0] nb;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd0, 2'd0, 4'd0, 2'd0, 4'd0, 1'b0, 6'd8},
        '{2'd1, 4'd1, 2'd1, 4'd2, 2'd2, 4'd1, 1'b1, 6'd5},
        '{2'd2, 4'd3, 2'd3, 4'd0, 2'd0, 4'd3, 1'b0, 6'd3},
        '{2'd3, 4'd4, 2'd0, 4'd4, 2'd3, 4'd2, 1'b1, 6'd2},
        '{2'd0, 4'd8, 2'd0, 4'd0, 2'd0, 4'd0, 1'b0, 6'd1},
        '{2'd0, 4'd0, 2'd1, 4'd0, 2'd2, 4'd0, 1'b0, 6'd0},
        '{2'd3, 4'd8, 2'd2, 4'd2, 2'd1, 4'd1, 1'b1, 6'd4}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cpol = 1'b0;
    logic [5:0] nbits = '0;
    logic [1:0] baud_pre = '0, lead_pre = '0, trail_pre = '0;
    logic [3:0] baud_scl = '0, lead_scl = '0, trail_scl = '0;
    logic sck, cs_act, edge_lead, edge_trail, done;
    int tests = 0, fails = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sck_cs_timer #(.NBITS_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .nbits(nbits), .cpol(cpol),
        .baud_pre(baud_pre), .baud_scl(baud_scl), .lead_pre(lead_pre),
        .lead_scl(lead_scl), .trail_pre(trail_pre), .trail_scl(trail_scl),
        .sck(sck), .cs_act(cs_act), .edge_lead(edge_lead),
        .edge_trail(edge_trail), .done(done));

    function automatic int baud_p(input logic [1:0] p, input logic [3:0] s);
        int f, v;
        case (p) 2'd0: f = 2; 2'd1: f = 3; 2'd2: f = 5; default: f = 7; endcase
        v = (s < 4) ? 2 * (int'(s) + 1) : (1 << s);
        return f * v;
    endfunction

    function automatic int dly(input logic [1:0] p, input logic [3:0] s);
        return (2 * int'(p) + 1) * (2 << s);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_frame(input vec_t v, input bit poke, input bit poke_fin);
        int per, h, dl, dt;
        int cs_cnt = 0, lead_gap = 0, edges = 0, trails = 0;
        int act_run = 0, act_max = 0, after_last = 0, done_cnt = 0;
        bit seen = 1'b0, got_done = 1'b0;
        per = baud_p(v.bp, v.bs); h = per / 2;
        dl = dly(v.lp, v.ls); dt = dly(v.tp, v.ts);
        @(negedge clk);
        baud_pre = v.bp; baud_scl = v.bs; lead_pre = v.lp; lead_scl = v.ls;
        trail_pre = v.tp; trail_scl = v.ts; cpol = v.cp; nbits = v.nb;
        start = 1'b1;
        for (int i = 1; i < 20000 && !got_done; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (poke && i == 3) begin
                start = 1'b1; baud_pre = 2'd3; baud_scl = 4'd15;
                lead_pre = 2'd3; lead_scl = 4'd15; nbits = 6'd63;
            end
            if (cs_act) cs_cnt++;
            if (cs_act && !seen && !edge_lead) lead_gap++;
            if (edge_lead) begin edges++; seen = 1'b1; end
            if (edge_trail) begin trails++; after_last = 0; end
            else if (cs_act && seen) after_last++;
            if (sck != v.cp) begin act_run++; if (act_run > act_max) act_max = act_run; end
            else act_run = 0;
            if (done) begin
                done_cnt++; got_done = 1'b1;
                chk("R7 cs low in done cycle", int'(cs_act), 0);
            end
        end
        chk("R7 frame completes with done", done_cnt, 1);
        if (v.nb != 0) begin
            chk("R5 total chip-select window", cs_cnt, dl + int'(v.nb) * per + dt);
            chk("R3 lead delay", lead_gap, dl);
            chk("R5 leading edges", edges, int'(v.nb));
            chk("R5 trailing edges", trails, int'(v.nb));
            chk("R2 active half length", act_max, h);
            chk("R4 trail delay", after_last, h - 1 + dt);
        end else begin
            chk("R6 zero-bit window", cs_cnt, dl + dt);
            chk("R6 no edges", edges + trails, 0);
            chk("R6 no sck activity", act_max, 0);
        end
        if (poke_fin) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R9 start in done cycle ignored", int'(cs_act), 0);
            @(negedge clk);
            chk("R9 no frame after ignored start", int'(cs_act), 0);
        end else begin
            @(negedge clk);
        end
        chk("R7 done lasts one cycle", int'(done), 0);
        chk("R2 idle sck level", int'(sck), int'(v.cp));
    endtask

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cs low in reset", int'(cs_act), 0);
        chk("R1 done low in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs low after reset", int'(cs_act), 0);
        chk("R1 strobes low after reset", int'(edge_lead) + int'(edge_trail) + int'(done), 0);
        chk("R2 idle sck with cpol 0", int'(sck), 0);
        cpol = 1'b1; #1;
        chk("R2 idle sck follows cpol 1", int'(sck), 1);

        for (int k = 0; k < NV; k++) run_frame(VECS[k], 1'b0, 1'b0);

        // R8 and R9: mid-frame start and code changes must not disturb the frame
        run_frame(VECS[1], 1'b1, 1'b0);
        // R9: start in the done cycle
        run_frame(VECS[0], 1'b0, 1'b1);
        // R8: zero-bit frame poked with a non-zero count stays edgeless
        run_frame(VECS[5], 1'b1, 1'b0);

        cpol = 1'b0; #1;
        chk("R2 idle sck follows cpol 0", int'(sck), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule